// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target side of an I2C link. It watches the open-drain SCL and SDA lines through synchronisers, finds START and STOP conditions, and takes part in a transfer only when the 7-bit address sent by the controller equals the address on its `own_addr_i` input. It never makes clock pulses. It only follows the edges the controller produces, and it may pull SCL low to make the controller wait.

Software sees two single-byte holding registers. Received bytes land in a receive register, and a full flag stays set until software strobes a read. Bytes to be sent are written into a transmit register with a load strobe, and an empty flag shows that the engine has taken the byte. When a received byte cannot be stored because the previous one is still unread, or when a byte must be sent and none has been loaded, the engine holds SCL low until software acts. The pad outputs are pull-down enables: a 1 on `scl_oe_o` or `sda_oe_o` drives the line low, and a 0 releases it.

Top module: `i2c_target`

## Requirements
- R1: After reset, and after any STOP, both pull-downs are released and `tx_role_o` is 0. After reset `rx_full_o` is 0 and `tx_empty_o` is 1.
- R2: The first byte after a START is the address: bits 7..1 are the address (sent MSB first) and bit 0 is R/W. The block pulls SDA low in the ninth clock only when bits 7..1 equal `own_addr_i`. On a mismatch it gives no ACK and ignores the bus until the next START: no ACKs, `rx_full_o` stays 0, nothing is driven (a controller read returns 8'hFF) and the transmit register is not taken.
- R3: With R/W = 0, each data byte is shifted in MSB first on rising SCL, copied to `rx_data_o` with `rx_full_o` set to 1, and acknowledged.
- R4: If a byte completes while `rx_full_o` is still 1, SCL is held low from the falling edge after bit 0 until `rx_read_i` is strobed. The new byte is then stored and acknowledged.
- R5: With R/W = 1 and a matching address, `tx_role_o` becomes 1 and bytes taken from the transmit register are driven MSB first, one bit per SCL low phase.
- R6: When a byte must be sent (after the address ACK or after an ACK from the controller) and `tx_empty_o` is 1, SCL is held low until `tx_load_i` is strobed.
- R7: A NACK from the controller after a data byte ends the transmission. SDA stays released until STOP or START, and a byte already loaded stays in the transmit register for a later read.
- R8: A repeated START in any state restarts the address phase, so the role can change from receiver to transmitter without a STOP.
- R9: SDA is changed only while SCL is low, and the block pulls SCL low only while SCL is already low. Its driven bits are therefore stable over each SCL high phase.
- R10: `rx_read_i` clears `rx_full_o`. `tx_load_i` sets `tx_empty_o` to 0. Taking a byte for transmission sets `tx_empty_o` to 1. A stored byte is never overwritten while unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Address this target answers to |
| rx_data_o | output | 8 | Last received data byte |
| rx_full_o | output | 1 | Receive register holds an unread byte |
| rx_read_i | input | 1 | Strobe: software has read `rx_data_o` |
| tx_data_i | input | 8 | Byte to send next |
| tx_load_i | input | 1 | Strobe: capture `tx_data_i` |
| tx_empty_o | output | 1 | Transmit register may be loaded |
| tx_role_o | output | 1 | 1 while addressed for a read |

## Verification
The hardest cases to reach are the two stretch windows. A receive stretch needs a second byte to complete while the first is still unread. A transmit stretch needs the engine to want a byte while software has loaded none. The bench reaches both by running the bus controller model and a software thread in parallel. The software thread holds back its read or its load for longer than a byte time. While it waits, the bench checks that SCL is being held, and afterwards that the controller model really found SCL held low. Random transactions also vary the software delay, so that some bytes are stretched and others are not.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_STALL,
    ST_RX_ACK,
    ST_TX_STALL,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stage_q[s] <= stage_q[s-1];
      stage_q[0] <= d_i;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o     = scl_q & scl_s_i & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_read_i,
  input  logic              tx_pop_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic [DATA_W-1:0] tx_hold_o,
  output logic              tx_empty_o
);
  logic [DATA_W-1:0] rx_data_q, tx_hold_q;
  logic              rx_full_q, tx_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      rx_full_q <= 1'b0;
    end else if (rx_push_i) begin
      rx_data_q <= rx_byte_i;
      rx_full_q <= 1'b1;
    end else if (rx_read_i) begin
      rx_full_q <= 1'b0;
    end
  end

  // load wins over pop: the old byte is taken, the new one stays held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_q  <= '0;
      tx_empty_q <= 1'b1;
    end else if (tx_load_i) begin
      tx_hold_q  <= tx_data_i;
      tx_empty_q <= 1'b0;
    end else if (tx_pop_i) begin
      tx_empty_q <= 1'b1;
    end
  end

  assign rx_data_o  = rx_data_q;
  assign rx_full_o  = rx_full_q;
  assign tx_hold_o  = tx_hold_q;
  assign tx_empty_o = tx_empty_q;

  p_rx_no_overwrite_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |-> !rx_full_q);

  p_tx_pop_has_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i |-> !tx_empty_q);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_hold_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              tx_pop_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              tx_role_o
);
  localparam int               CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              sda_oe_q, sda_oe_d;
  logic              scl_oe_q, scl_oe_d;
  logic              tx_role_q, tx_role_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              in_stall;

  assign in_stall = (state_q == ST_RX_STALL) || (state_q == ST_TX_STALL);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sr_d      = sr_q;
    sda_oe_d  = sda_oe_q;
    scl_oe_d  = scl_oe_q & in_stall;  // hold drops the cycle after a stall ends
    tx_role_d = tx_role_q;
    rw_d      = rw_q;
    nack_d    = nack_q;
    rx_push_o = 1'b0;
    tx_pop_o  = 1'b0;

    if (stop_i) begin
      state_d   = ST_IDLE;
      cnt_d     = '0;
      sda_oe_d  = 1'b0;
      scl_oe_d  = 1'b0;
      tx_role_d = 1'b0;
    end else if (start_i) begin
      state_d   = ST_ADDR;
      cnt_d     = '0;
      sda_oe_d  = 1'b0;
      scl_oe_d  = 1'b0;
      tx_role_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sr_d  = {sr_q[DATA_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (sr_q[DATA_W-1:1] == own_addr_i) begin
              sda_oe_d = 1'b1;
              rw_d     = sr_q[0];
              state_d  = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            sda_oe_d = 1'b0;
            if (rw_q) begin
              tx_role_d = 1'b1;
              scl_oe_d  = 1'b1;
              state_d   = ST_TX_STALL;
            end else begin
              state_d = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            sr_d  = {sr_q[DATA_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            cnt_d    = '0;
            scl_oe_d = 1'b1;
            state_d  = ST_RX_STALL;
          end
        end
        ST_RX_STALL: begin
          if (!rx_full_i) begin
            rx_push_o = 1'b1;
            sda_oe_d  = 1'b1;
            state_d   = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            sda_oe_d = 1'b0;
            state_d  = ST_RX;
          end
        end
        ST_TX_STALL: begin
          if (!tx_empty_i) begin
            tx_pop_o = 1'b1;
            sr_d     = tx_hold_i;
            sda_oe_d = ~tx_hold_i[DATA_W-1];
            cnt_d    = '0;
            state_d  = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              sda_oe_d = 1'b0;
              cnt_d    = '0;
              state_d  = ST_TX_ACK;
            end else begin
              sr_d     = {sr_q[DATA_W-2:0], 1'b0};
              sda_oe_d = ~sr_q[DATA_W-2];
              cnt_d    = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            nack_d = sda_s_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_d = ST_WAIT;
            end else begin
              scl_oe_d = 1'b1;
              state_d  = ST_TX_STALL;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      sda_oe_q  <= 1'b0;
      scl_oe_q  <= 1'b0;
      tx_role_q <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sr_q      <= sr_d;
      sda_oe_q  <= sda_oe_d;
      scl_oe_q  <= scl_oe_d;
      tx_role_q <= tx_role_d;
      rw_q      <= rw_d;
      nack_q    <= nack_d;
    end
  end

  assign rx_byte_o = sr_q;
  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = scl_oe_q;
  assign tx_role_o = tx_role_q;

  p_sda_moves_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_q) && !$past(start_i) && !$past(stop_i)) |-> !$past(scl_s_i));

  p_stretch_when_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_q) |-> !scl_s_i);

  p_tx_role_from_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_role_q) |-> $past(state_q == ST_ADDR_ACK));

  p_stop_releases_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> (!sda_oe_q && !scl_oe_q && !tx_role_q));
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [DATA_W-2:0] own_addr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  input  logic              rx_read_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_empty_o,
  output logic              tx_role_o
);
  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              rx_push, tx_pop, rx_full, tx_empty;
  logic [DATA_W-1:0] rx_byte, tx_hold;

  i2c_tgt_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  i2c_tgt_bus_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_tgt_engine #(.DATA_W(DATA_W)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .own_addr_i(own_addr_i),
    .rx_full_i (rx_full),
    .tx_empty_i(tx_empty),
    .tx_hold_i (tx_hold),
    .rx_push_o (rx_push),
    .rx_byte_o (rx_byte),
    .tx_pop_o  (tx_pop),
    .sda_oe_o  (sda_oe_o),
    .scl_oe_o  (scl_oe_o),
    .tx_role_o (tx_role_o)
  );

  i2c_tgt_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_push_i (rx_push),
    .rx_byte_i (rx_byte),
    .rx_read_i (rx_read_i),
    .tx_pop_i  (tx_pop),
    .tx_load_i (tx_load_i),
    .tx_data_i (tx_data_i),
    .rx_data_o (rx_data_o),
    .rx_full_o (rx_full),
    .tx_hold_o (tx_hold),
    .tx_empty_o(tx_empty)
  );

  assign rx_full_o  = rx_full;
  assign tx_empty_o = tx_empty;
endmodule

// File: tb/test_i2c_target.sv
module test_i2c_target;
  localparam int       CLK_PERIOD = 10;
  localparam int       HALF       = 16;
  localparam int       QTR        = 4;
  localparam logic [6:0] OWN      = 7'h3A;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       m_scl, m_sda;
  logic       scl_bus, sda_bus;
  logic       scl_oe, sda_oe;
  logic [6:0] own_addr;
  logic [7:0] rx_data, tx_data;
  logic       rx_full, rx_read, tx_load, tx_empty, tx_role;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  r9_moves = 0;
  bit  stretch_seen = 1'b0;
  bit  done = 1'b0;

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_target i_i2c_target (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl_bus),
    .sda_i     (sda_bus),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe),
    .own_addr_i(own_addr),
    .rx_data_o (rx_data),
    .rx_full_o (rx_full),
    .rx_read_i (rx_read),
    .tx_data_i (tx_data),
    .tx_load_i (tx_load),
    .tx_empty_o(tx_empty),
    .tx_role_o (tx_role)
  );

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic [6:0] other_addr(input int unsigned r);
    return OWN ^ 7'(1 + (r % 127));
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high(output logic sda_first);
    int n = 0;
    m_scl = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!scl_bus && n < 4000);
    if (n > 3) stretch_seen = 1'b1;
    sda_first = sda_bus;
    wait_clks(HALF);
  endtask

  task automatic m_start();
    logic d;
    m_sda = 1'b1;
    wait_clks(QTR);
    scl_high(d);
    m_sda = 1'b0;
    wait_clks(HALF);
    m_scl = 1'b0;
    wait_clks(QTR);
  endtask

  task automatic m_stop();
    logic d;
    m_sda = 1'b0;
    wait_clks(HALF);
    scl_high(d);
    m_sda = 1'b1;
    wait_clks(HALF);
  endtask

  task automatic put_bit(input logic b);
    logic d;
    m_sda = b;
    wait_clks(HALF);
    scl_high(d);
    m_scl = 1'b0;
    wait_clks(QTR);
  endtask

  task automatic get_bit(output logic b);
    logic first;
    m_sda = 1'b1;
    wait_clks(HALF);
    scl_high(first);
    b = sda_bus;
    if (first !== b) r9_moves++;
    m_scl = 1'b0;
    wait_clks(QTR);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic sw_read();
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic sw_load(input logic [7:0] v);
    tx_data = v;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic       ack;
    logic [7:0] got;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_ni = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    rx_read = 1'b0; tx_load = 1'b0; tx_data = '0; own_addr = OWN;
    wait_clks(5);
    rst_ni = 1'b1;
    wait_clks(5);

    // R1 reset state
    check("R1 scl_oe after reset", scl_oe, 0);
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 tx_role after reset", tx_role, 0);
    check("R1 rx_full after reset", rx_full, 0);
    check("R1 tx_empty after reset", tx_empty, 1);

    // R2/R3 write of two bytes, read promptly
    m_start();
    send_byte(addr_byte(OWN, 1'b0), ack);
    check("R2 ack on own address", ack, 1);
    send_byte(8'hA5, ack);
    check("R3 ack data", ack, 1);
    check("R3 rx_full set", rx_full, 1);
    check("R3 rx_data MSB first", rx_data, 8'hA5);
    sw_read();
    wait_clks(1);
    check("R10 read clears rx_full", rx_full, 0);
    send_byte(8'h01, ack);
    check("R3 rx_data second", rx_data, 8'h01);
    sw_read();
    m_stop();
    check("R1 released after stop", {scl_oe, sda_oe, tx_role}, 0);

    // R4 receive stretch
    m_start();
    send_byte(addr_byte(OWN, 1'b0), ack);
    send_byte(8'h3C, ack);
    stretch_seen = 1'b0;
    fork
      send_byte(8'hC3, ack);
      begin
        wait_clks(700);
        check("R4 SCL held while unread", scl_oe, 1);
        check("R10 unread byte kept", rx_data, 8'h3C);
        sw_read();
      end
    join
    check("R4 controller saw stretch", stretch_seen, 1);
    check("R4 ack after release", ack, 1);
    check("R4 second byte stored", rx_data, 8'hC3);
    sw_read();
    m_stop();

    // R2 mismatch: ignored until next START
    m_start();
    send_byte(addr_byte(other_addr(5), 1'b0), ack);
    check("R2 no ack on other address", ack, 0);
    send_byte(8'h55, ack);
    check("R2 data ignored no ack", ack, 0);
    check("R2 rx_full untouched", rx_full, 0);
    m_stop();

    // R5 read with preloaded data
    sw_load(8'h96);
    check("R10 load clears tx_empty", tx_empty, 0);
    m_start();
    send_byte(addr_byte(OWN, 1'b1), ack);
    check("R5 ack read address", ack, 1);
    check("R5 tx_role set", tx_role, 1);
    check("R10 byte taken sets tx_empty", tx_empty, 1);
    sw_load(8'h4B);
    recv_byte(got, 1'b1);
    check("R5 first byte", got, 8'h96);
    recv_byte(got, 1'b0);
    check("R5 second byte", got, 8'h4B);
    m_stop();
    check("R1 tx_role cleared by stop", tx_role, 0);

    // R6 transmit stretch
    stretch_seen = 1'b0;
    fork
      begin
        m_start();
        send_byte(addr_byte(OWN, 1'b1), ack);
        recv_byte(got, 1'b0);
      end
      begin
        int n = 0;
        while (!scl_oe && n < 3000) begin @(negedge clk); n++; end
        wait_clks(200);
        check("R6 SCL held while tx empty", scl_oe, 1);
        sw_load(8'hE7);
      end
    join
    check("R6 controller saw stretch", stretch_seen, 1);
    check("R6 byte after load", got, 8'hE7);
    m_stop();

    // R7 NACK ends transmission, loaded byte kept
    sw_load(8'h5A);
    m_start();
    send_byte(addr_byte(OWN, 1'b1), ack);
    sw_load(8'hB2);
    recv_byte(got, 1'b0);
    check("R7 byte before nack", got, 8'h5A);
    recv_byte(got, 1'b0);
    check("R7 bus released after nack", got, 8'hFF);
    check("R7 loaded byte kept", tx_empty, 0);
    m_stop();
    m_start();
    send_byte(addr_byte(OWN, 1'b1), ack);
    recv_byte(got, 1'b0);
    check("R7 kept byte sent later", got, 8'hB2);
    m_stop();

    // R8 repeated START switches write to read; mismatch then own
    m_start();
    send_byte(addr_byte(OWN, 1'b0), ack);
    send_byte(8'h77, ack);
    sw_read();
    check("R8 receiver before restart", tx_role, 0);
    sw_load(8'h2D);
    m_start();
    send_byte(addr_byte(OWN, 1'b1), ack);
    check("R8 ack after repeated start", ack, 1);
    check("R8 transmitter after restart", tx_role, 1);
    recv_byte(got, 1'b0);
    check("R8 data after restart", got, 8'h2D);
    m_start();
    send_byte(addr_byte(other_addr(9), 1'b0), ack);
    check("R8 mismatch after restart", ack, 0);
    m_start();
    send_byte(addr_byte(OWN, 1'b0), ack);
    check("R8 own after mismatch restart", ack, 1);
    m_stop();

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [7:0]  d [4];
      logic        match, rw;
      int          nb;
      logic [6:0]  a;
      match = ($urandom % 4) != 0;
      rw    = 1'($urandom % 2);
      nb    = 1 + int'($urandom % 4);
      a     = match ? OWN : other_addr($urandom);
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      if (rw && match) sw_load(d[0]);
      m_start();
      send_byte(addr_byte(a, rw), ack);
      check("R2 random address ack", ack, match);
      if (!match) begin
        if (rw) begin
          recv_byte(got, 1'b0);
          check("R2 random ignored read", got, 8'hFF);
          check("R2 tx untouched", tx_empty, 1);
        end else begin
          send_byte(d[0], ack);
          check("R2 random ignored write", {ack, rx_full}, 0);
        end
      end else if (!rw) begin
        for (int i = 0; i < nb; i++) begin
          fork
            send_byte(d[i], ack);
            begin
              if (i > 0) begin
                wait_clks(int'($urandom % 500));
                check("R3 random rx_data", {rx_full, rx_data}, {1'b1, d[i-1]});
                sw_read();
              end
            end
          join
          check("R3 random ack", ack, 1);
        end
        wait_clks(2);
        check("R3 random last byte", {rx_full, rx_data}, {1'b1, d[nb-1]});
        sw_read();
      end else begin
        for (int i = 0; i < nb; i++) begin
          fork
            recv_byte(got, i < nb - 1);
            begin
              if (i < nb - 1) begin
                wait_clks(int'($urandom % 500));
                sw_load(d[i+1]);
              end
            end
          join
          check("R5 random tx byte", got, d[i]);
        end
      end
      m_stop();
      check("R1 random released after stop", {scl_oe, sda_oe, tx_role}, 0);
    end

    check("R9 driven SDA stable while SCL high", r9_moves, 0);

    done = 1'b1;
    finish_run();
  end
endmodule